// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one DMA channel. It copies operands from a source address to a destination address through a simple bus master port. Software writes five registers through a write-only configuration port: source address, destination address, byte count, control and status. Writing the start bit in the control register launches the channel. Each operand is read into a holding register and then written out. After each operand the enabled addresses step by the operand size and the byte count steps down by the same amount. The channel stops with a done flag and a one-cycle interrupt once the count is exhausted. It stops with an error flag if a bus cycle ends in an error response.

The channel is paced in one of two ways. In internal request mode it runs operand after operand with no gaps other than its own arming state. In external request mode it waits for the `dreq` level before each operand. In single-address mode each request runs one bus cycle only: a read from the source address, or a write to the destination address, chosen by a control bit. The other address register plays no part in that mode.

The sequencer has four states, named in the requirements below. IDLE waits for a start. ARM checks the start bit, the count and the request. RD runs a read cycle. WR runs a write cycle. The transitions are:
- IDLE→ARM: on start.
- ARM→IDLE: on halt, or on done.
- ARM→RD and ARM→WR: on launch.
- RD→WR: on the read acknowledge in dual mode.
- RD→ARM and WR→ARM: on an acknowledge that completes an operand.
- RD→IDLE and WR→IDLE: on an error response.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `bus_req`, `busy`, `done`, `err` and `irq` are all 0.
- R2: Configuration selects are: 0 source address, 1 destination address, 2 byte count, 3 control, 4 status. Control bits are: bit0 start, bit1 external request, bit2 single-address, bit3 single-address cycle is a write, bit4 source increment, bit5 destination increment, bits[7:6] operand size (0 byte, 1 word, 2 or 3 long). In dual-address mode every operand is a read (`bus_we`=0) from the source address followed by a write (`bus_we`=1) to the destination address carrying the read data. An enabled address advances by 1, 2 or 4 after its cycle.
- R3: The byte count drops by 1, 2 or 4 per completed operand. A count below the step becomes 0, and the count never rises except when software loads it.
- R4: An address whose increment bit is 0 stays the same for every operand.
- R5: In ARM, a count of 0 sends the channel to IDLE. This clears start, sets `done` and pulses `irq` high for exactly one cycle. A start with a count of 0 runs no bus cycle.
- R6: In external mode the channel leaves ARM only while `dreq` is 1. `dreq` has no effect while start is 0.
- R7: In single-address mode each operand is one cycle. With bit3=0 it is a read from the source address; with bit3=1 it is a write to the destination address.
- R8: An error response ends the channel: it goes to IDLE, clears start and sets `err`. The address used in the faulted cycle still advances, but the count does not. No bus cycle follows.
- R9: Clearing start while the channel is active lets the current read/write pair finish. The channel then goes to IDLE without setting `done`.
- R10: While `done` or `err` is set, start is not acted on. Writing 1s to status bits 0 (done) and 1 (err) clears them.
- R11: Once `bus_req` is raised, `bus_addr` and `bus_we` hold until `bus_ack` or `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (R2) |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | 1 | External transfer request level |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Cycle address |
| bus_size | output | 2 | Operand size code |
| bus_wdata | output | DW | Write data from the holding register |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Normal end of cycle |
| bus_err | input | 1 | Error end of cycle |
| busy | output | 1 | Channel not in IDLE |
| done | output | 1 | Count exhausted flag |
| err | output | 1 | Bus error flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the bus never raises `bus_ack` or `bus_err` without `bus_req`, and never raises both at once. They also assume that software does not reload the byte count in the same cycle that the channel signals done. The bench slave answers only a pending request, with one response per cycle, and the stimulus writes configuration only while the channel is idle. The one exception is the halt case, where only the control register is rewritten.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD,
        ST_WR
    } dma_state_e;

    localparam int CB_START  = 0;
    localparam int CB_EXT    = 1;
    localparam int CB_SINGLE = 2;
    localparam int CB_SA_WR  = 3;
    localparam int CB_SINC   = 4;
    localparam int CB_DINC   = 5;
    localparam int CB_SZ_LO  = 6;
    localparam int CTRL_W    = 8;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    function automatic logic [2:0] size_step(input logic [1:0] sz);
        logic [2:0] s;
        unique case (sz)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_step_ctr.sv
module dma_step_ctr #(
    parameter int W    = 32,
    parameter bit DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [2:0]   step,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] stepw;
    logic [W-1:0] nxt;

    assign stepw = W'(step);

    generate
        if (DOWN) begin : g_down
            assign nxt = (q < stepw) ? ZERO : q - stepw;

            p_cnt_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !ld |=> q <= $past(q));
        end else begin : g_up
            assign nxt = q + stepw;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= ZERO;
        else if (ld)  q <= ld_val;
        else if (adv) q <= nxt;
    end
endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CTRL_W-1:0] cfg_wbyte,
    input  logic              clr_start,
    input  logic              set_done,
    input  logic              set_err,
    output logic [CTRL_W-1:0] ctrl,
    output logic              done,
    output logic              err
);
    logic wr_ctrl, wr_stat;

    assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
    assign wr_stat = cfg_we && (cfg_sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= cfg_wbyte;
        end else if (clr_start) begin
            ctrl[CB_START] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (set_done)                  done <= 1'b1;
            else if (wr_stat && cfg_wbyte[0]) done <= 1'b0;
            if (set_err)                   err  <= 1'b1;
            else if (wr_stat && cfg_wbyte[1]) err  <= 1'b0;
        end
    end

    p_stat_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_stat) |=> done);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ext_mode,
    input  logic       single,
    input  logic       sa_wr,
    input  logic       blocked,
    input  logic       cnt_zero,
    input  logic       dreq,
    input  logic       bus_ack,
    input  logic       bus_err,
    output dma_state_e state,
    output logic       bus_req,
    output logic       bus_we,
    output logic       use_dst,
    output logic       adv_src,
    output logic       adv_dst,
    output logic       adv_cnt,
    output logic       cap,
    output logic       set_done,
    output logic       set_err,
    output logic       clr_start
);
    dma_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        use_dst   = 1'b0;
        adv_src   = 1'b0;
        adv_dst   = 1'b0;
        adv_cnt   = 1'b0;
        cap       = 1'b0;
        set_done  = 1'b0;
        set_err   = 1'b0;
        clr_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start && !blocked) nxt = ST_ARM;
            end
            ST_ARM: begin
                if (!start) begin
                    nxt = ST_IDLE;
                end else if (cnt_zero) begin
                    set_done  = 1'b1;
                    clr_start = 1'b1;
                    nxt       = ST_IDLE;
                end else if (!ext_mode || dreq) begin
                    nxt = (single && sa_wr) ? ST_WR : ST_RD;
                end
            end
            ST_RD: begin
                bus_req = 1'b1;
                if (bus_err) begin
                    adv_src   = 1'b1;
                    set_err   = 1'b1;
                    clr_start = 1'b1;
                    nxt       = ST_IDLE;
                end else if (bus_ack) begin
                    adv_src = 1'b1;
                    cap     = 1'b1;
                    if (single) begin
                        adv_cnt = 1'b1;
                        nxt     = ST_ARM;
                    end else begin
                        nxt = ST_WR;
                    end
                end
            end
            ST_WR: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                use_dst = 1'b1;
                if (bus_err) begin
                    adv_dst   = 1'b1;
                    set_err   = 1'b1;
                    clr_start = 1'b1;
                    nxt       = ST_IDLE;
                end else if (bus_ack) begin
                    adv_dst = 1'b1;
                    adv_cnt = 1'b1;
                    nxt     = ST_ARM;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    p_ext_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && ext_mode && !dreq) |=> !bus_req);

    p_cycle_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_we)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          dreq,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          irq
);
    localparam int LW = (AW > CW) ? AW : CW;

    logic [CTRL_W-1:0] ctrl;
    logic [AW-1:0]     src_q, dst_q;
    logic [CW-1:0]     cnt_q;
    logic [LW-1:0]     ld_word;
    logic [2:0]        step;
    logic [DW-1:0]     hold_q;
    dma_state_e        state;
    logic use_dst, adv_src, adv_dst, adv_cnt, cap;
    logic set_done, set_err, clr_start;

    assign ld_word  = LW'(cfg_wdata);
    assign bus_size = ctrl[CB_SZ_LO +: 2];
    assign step     = size_step(bus_size);

    dma_ctrl_reg u_regs (
        .clk, .rst_n, .cfg_we, .cfg_sel,
        .cfg_wbyte (cfg_wdata[CTRL_W-1:0]),
        .clr_start, .set_done, .set_err,
        .ctrl, .done, .err
    );

    dma_step_ctr #(.W(AW), .DOWN(1'b0)) u_src (
        .clk, .rst_n,
        .ld     (cfg_we && cfg_sel == SEL_SRC),
        .ld_val (ld_word[AW-1:0]),
        .adv    (adv_src && ctrl[CB_SINC]),
        .step, .q (src_q)
    );

    dma_step_ctr #(.W(AW), .DOWN(1'b0)) u_dst (
        .clk, .rst_n,
        .ld     (cfg_we && cfg_sel == SEL_DST),
        .ld_val (ld_word[AW-1:0]),
        .adv    (adv_dst && ctrl[CB_DINC]),
        .step, .q (dst_q)
    );

    dma_step_ctr #(.W(CW), .DOWN(1'b1)) u_cnt (
        .clk, .rst_n,
        .ld     (cfg_we && cfg_sel == SEL_CNT),
        .ld_val (ld_word[CW-1:0]),
        .adv    (adv_cnt),
        .step, .q (cnt_q)
    );

    dma_fsm u_fsm (
        .clk, .rst_n,
        .start    (ctrl[CB_START]),
        .ext_mode (ctrl[CB_EXT]),
        .single   (ctrl[CB_SINGLE]),
        .sa_wr    (ctrl[CB_SA_WR]),
        .blocked  (done || err),
        .cnt_zero (cnt_q == '0),
        .dreq, .bus_ack, .bus_err,
        .state, .bus_req, .bus_we, .use_dst,
        .adv_src, .adv_dst, .adv_cnt, .cap,
        .set_done, .set_err, .clr_start
    );

    always_ff @(posedge clk) begin
        if (!rst_n)   hold_q <= '0;
        else if (cap) hold_q <= bus_rdata;
    end

    assign bus_addr  = use_dst ? dst_q : src_q;
    assign bus_wdata = hold_q;
    assign busy      = (state != ST_IDLE);
    assign irq       = set_done;

    p_addr_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=> $stable(bus_addr));

    p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err) |=> !bus_req);

    p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(cnt_q) == '0));

    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic        chk;
        string       req;
    } xact_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dreq = 1'b0;
    logic        bus_req, bus_we, busy, done, err, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;

    logic        err_armed = 1'b0;
    logic [31:0] err_addr = '0;

    int n_chk = 0, n_err = 0, n_seen = 0, n_irq = 0, cyc = 0;
    xact_t exp_q[$];

    always #4 clk = ~clk;

    dma_chan_seq u0 (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .dreq,
        .bus_req, .bus_we, .bus_addr, .bus_size, .bus_wdata,
        .bus_rdata, .bus_ack, .bus_err, .busy, .done, .err, .irq
    );

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return 32'h5A00_0000 ^ {a[15:0], a[15:0]} ^ 32'h0000_1357;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // bus slave: one response per request, one cycle after the request is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end else if (bus_req && !bus_ack && !bus_err) begin
            if (err_armed && bus_addr == err_addr) bus_err <= 1'b1;
            else                                   bus_ack <= 1'b1;
            bus_rdata <= rd_val(bus_addr);
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    // monitor: pops the scoreboard on every finished bus cycle
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (irq) n_irq++;
            if (bus_req && (bus_ack || bus_err)) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected bus cycle addr", bus_addr, 32'h0);
                end else begin
                    xact_t e;
                    e = exp_q.pop_front();
                    check(bus_we == e.we, e.req, "direction", 32'(bus_we), 32'(e.we));
                    check(bus_addr == e.addr, e.req, "address", bus_addr, e.addr);
                    if (e.chk)
                        check(bus_wdata == e.data, e.req, "write data", bus_wdata, e.data);
                end
            end
        end
    end

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic chk, input string req);
        xact_t e;
        e.we = we; e.addr = a; e.data = d; e.chk = chk; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_run(input logic [31:0] src, input logic [31:0] dst,
                            input int sz, input bit sinc, input bit dinc,
                            input int cnt, input bit single, input bit sa_wr,
                            input string req);
        int st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        logic [31:0] s = src, d = dst;
        int c = cnt;
        while (c != 0) begin
            if (single) begin
                if (sa_wr) push(1'b1, d, 32'h0, 1'b0, req);
                else       push(1'b0, s, 32'h0, 1'b0, req);
            end else begin
                push(1'b0, s, 32'h0, 1'b0, req);
                push(1'b1, d, rd_val(s), 1'b1, req);
            end
            if (sinc) s = s + st;
            if (dinc) d = d + st;
            c = (c < st) ? 0 : c - st;
        end
    endtask

    task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input int c);
        cfg_wr(3'd0, s);
        cfg_wr(3'd1, d);
        cfg_wr(3'd2, 32'(c));
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || busy) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n < 2000, req, "channel drained", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        while (cyc < 20000) @(negedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seen0, irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !busy, "R1", "idle after reset", {bus_req, busy}, 0);
        check(!done && !err && !irq, "R1", "flags after reset", {done, err, irq}, 0);

        // R2: dual-address long, both addresses increment
        load(32'h1000, 32'h2000, 12);
        push_run(32'h1000, 32'h2000, 2, 1, 1, 12, 0, 0, "R2");
        cfg_wr(3'd3, 32'hB1);
        drain("R2");
        check(done && !err, "R5", "done after count", {done, err}, 2'b10);
        check(n_irq == 1, "R5", "irq pulses", n_irq, 1);

        // R10: start ignored while done is still set
        seen0 = n_seen;
        cfg_wr(3'd3, 32'hB1);
        repeat (20) @(negedge clk);
        check(!busy && n_seen == seen0, "R10", "blocked start", n_seen - seen0, 0);
        cfg_wr(3'd3, 32'h0);
        cfg_wr(3'd4, 32'h3);
        check(!done && !err, "R10", "status cleared", {done, err}, 0);

        // R4: word, source increments, destination fixed
        load(32'h3000, 32'h4000, 6);
        push_run(32'h3000, 32'h4000, 1, 1, 0, 6, 0, 0, "R4");
        cfg_wr(3'd3, 32'h51);
        drain("R4");
        cfg_wr(3'd4, 32'h3);

        // R2: byte operands, unaligned start
        load(32'h5001, 32'h6003, 3);
        push_run(32'h5001, 32'h6003, 0, 1, 1, 3, 0, 0, "R2");
        cfg_wr(3'd3, 32'h31);
        drain("R2");
        cfg_wr(3'd4, 32'h3);

        // R3: count 5 with long operands saturates after two operands
        load(32'h1100, 32'h2100, 5);
        push_run(32'h1100, 32'h2100, 2, 1, 1, 8, 0, 0, "R3");
        cfg_wr(3'd3, 32'hB1);
        drain("R3");
        check(done, "R3", "done after saturation", 32'(done), 1);
        cfg_wr(3'd4, 32'h3);

        // R5: zero count
        seen0 = n_seen; irq0 = n_irq;
        cfg_wr(3'd2, 32'h0);
        cfg_wr(3'd3, 32'hB1);
        repeat (5) @(negedge clk);
        check(done && n_seen == seen0, "R5", "zero count no cycle", n_seen - seen0, 0);
        check(n_irq == irq0 + 1, "R5", "zero count irq", n_irq - irq0, 1);
        cfg_wr(3'd4, 32'h3);

        // R6: dreq ignored while not started, then gates each operand
        load(32'h7100, 32'h7200, 8);
        seen0 = n_seen;
        dreq = 1'b1;
        cfg_wr(3'd3, 32'hB2);
        repeat (10) @(negedge clk);
        check(!busy && n_seen == seen0, "R6", "dreq while stopped", 32'(busy), 0);
        dreq = 1'b0;
        push_run(32'h7100, 32'h7200, 2, 1, 1, 8, 0, 0, "R6");
        cfg_wr(3'd3, 32'hB3);
        repeat (15) @(negedge clk);
        check(busy && !bus_req && n_seen == seen0, "R6", "waits for dreq", n_seen - seen0, 0);
        dreq = 1'b1;
        drain("R6");
        dreq = 1'b0;
        check(done, "R6", "done after dreq", 32'(done), 1);
        cfg_wr(3'd4, 32'h3);

        // R7: single-address read, then single-address write
        load(32'h7000, 32'h7800, 8);
        push_run(32'h7000, 32'h7800, 1, 1, 0, 8, 1, 0, "R7");
        cfg_wr(3'd3, 32'h55);
        drain("R7");
        cfg_wr(3'd4, 32'h3);
        load(32'h7000, 32'h7800, 4);
        push_run(32'h7000, 32'h7800, 1, 0, 1, 4, 1, 1, "R7");
        cfg_wr(3'd3, 32'h6D);
        drain("R7");
        check(done, "R7", "single done", 32'(done), 1);
        cfg_wr(3'd4, 32'h3);

        // R8: error on second read; restart resumes past the faulted address
        load(32'h100, 32'h200, 8);
        err_addr = 32'h104; err_armed = 1'b1;
        push(1'b0, 32'h100, 0, 1'b0, "R8");
        push(1'b1, 32'h200, rd_val(32'h100), 1'b1, "R8");
        push(1'b0, 32'h104, 0, 1'b0, "R8");
        cfg_wr(3'd3, 32'hB1);
        drain("R8");
        repeat (5) @(negedge clk);
        check(err && !done && !busy, "R8", "error stop", {err, done, busy}, 3'b100);
        err_armed = 1'b0;
        cfg_wr(3'd4, 32'h3);
        push(1'b0, 32'h108, 0, 1'b0, "R8");
        push(1'b1, 32'h204, rd_val(32'h108), 1'b1, "R8");
        cfg_wr(3'd3, 32'hB1);
        drain("R8");
        check(done && !err, "R8", "resumed run done", {done, err}, 2'b10);
        cfg_wr(3'd4, 32'h3);

        // R9: clear start during the first read
        load(32'h8000, 32'h9000, 40);
        push(1'b0, 32'h8000, 0, 1'b0, "R9");
        push(1'b1, 32'h9000, rd_val(32'h8000), 1'b1, "R9");
        cfg_wr(3'd3, 32'hB1);
        while (!bus_req) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'hB0;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pair completed", 32'(exp_q.size()), 0);
        check(!busy && !done, "R9", "halted without done", {busy, done}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule